// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Target

This block is an I2C target that fronts a 2048-byte on-chip memory. A fast system clock oversamples the bus clock and data lines, finds START and STOP conditions, and shifts bytes in and out MSB first. The block never drives the data line high. It only pulls it low, through an output-enable that the chip pad turns into an open-drain driver. The pad returns the resolved line level on the data input.

A host opens a transaction with a device byte. That byte holds a fixed 4-bit code, the three upper memory-address bits and a read/write flag. A write transaction then carries the low address byte and any number of data bytes, which land at consecutive addresses. A read transaction returns bytes from a stored next-address pointer until the host declines a byte. The pointer keeps its value between transactions. This gives current-address reads, and it gives random reads through a repeated START. A write-protect input blocks all memory updates and leaves the bus protocol as it is.

Top module: `i2cm_target`

## Requirements
- R1: After reset the target leaves SDA released, waits for a START, and holds its next-address pointer at 0x000, so a first read with upper bits 0 returns address 0x000.
- R2: The device byte is code 1010 in bits [7:4], upper address bits in [3:1] and R/W in bit 0 (1 = read). On a code match the target pulls SDA low on the 9th clock. With any other code it leaves SDA high and ignores the bus until the next START.
- R3: In a write transaction, the byte after the device byte sets address bits [7:0]. Each further byte is stored at the pointer, and every byte is acknowledged.
- R4: The pointer advances by one after every stored or transmitted byte across all 11 bits, and wraps from 0x7FF to 0x000.
- R5: A read device byte without a preceding address reads from {device-byte bits [3:1], pointer bits [7:0]}.
- R6: A write device byte and a low address byte, followed by a repeated START and a read device byte, return the byte at the given address first.
- R7: While the host acknowledges, the target sends the bytes at consecutive addresses. After a host NACK it releases SDA and idles.
- R8: While WP is high, data bytes are still acknowledged and the pointer still advances, but memory does not change.
- R9: A STOP before a data byte is complete discards that byte, and memory is unchanged.
- R10: The target changes its SDA drive only after an SCL falling edge, a START or a STOP. It never changes the drive while SCL is high otherwise.
- R11: A START inside a byte abandons that byte and restarts device-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level from the pad |
| sda_i | input | 1 | Resolved bus data level from the pad |
| wp_i | input | 1 | Write protect, 1 blocks memory updates |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
A wrong pointer shows up at the ports on the first byte of the next read. That byte comes from the neighbouring address. Single-byte reads at the wrap point and right after a reset expose such an error at once. A bad write strobe, whether under write protect or from a partial byte, stays hidden until that address is read back. For this reason every such case is followed directly by a read of the same location. A bit-counter or framing error moves the acknowledge off the 9th clock, so the bench sees a missing ACK within the same byte.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK_OUT,
        S_TX,
        S_ACK_IN
    } tgt_state_e;

    typedef enum logic [1:0] {
        P_DEV,
        P_ADDR,
        P_DATA
    } rx_phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic code_match(input logic [BYTE_W-1:0] b, input logic [3:0] code);
        return b[BYTE_W-1 -: 4] == code;
    endfunction

endpackage

// File: rtl/i2cm_bus_sampler.sv
module i2cm_bus_sampler
    import i2cm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_prev;
    logic                   sda_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= scl_i;
                    sda_sync <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
                    sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_sync[LAST];
            sda_prev <= sda_sync[LAST];
        end
    end

    always_comb begin
        ev.sda   = sda_sync[LAST];
        ev.rise  = scl_sync[LAST] & ~scl_prev;
        ev.fall  = ~scl_sync[LAST] & scl_prev;
        ev.start = scl_sync[LAST] & scl_prev & sda_prev & ~sda_sync[LAST];
        ev.stop  = scl_sync[LAST] & scl_prev & ~sda_prev & sda_sync[LAST];
    end

endmodule

// File: rtl/i2cm_mem_array.sv
module i2cm_mem_array #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/i2cm_target.sv
module i2cm_target
    import i2cm_pkg::*;
#(
    parameter int         ADDR_W      = 11,
    parameter logic [3:0] DEV_CODE    = 4'b1010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe
);
    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    bus_ev_t             ev;
    tgt_state_e          state;
    rx_phase_e           phase;
    logic [CNT_W-1:0]    bitcnt;
    logic [BYTE_W-1:0]   rx_sh;
    logic [BYTE_W-1:0]   tx_sh;
    logic                rw_q;
    logic                host_ack_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                oe_q;
    logic                mem_we;
    logic [ADDR_W-1:0]   mem_waddr;
    logic [BYTE_W-1:0]   mem_wdata;
    logic [BYTE_W-1:0]   rdata;
    logic                byte_done;

    i2cm_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cm_mem_array #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (addr_q),
        .rdata (rdata)
    );

    assign byte_done = (state == S_RX) && ev.fall && (bitcnt == CNT_FULL);
    assign sda_oe    = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            phase      <= P_DEV;
            bitcnt     <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            rw_q       <= 1'b0;
            host_ack_q <= 1'b0;
            addr_q     <= '0;
            oe_q       <= 1'b0;
            mem_we     <= 1'b0;
            mem_waddr  <= '0;
            mem_wdata  <= '0;
        end else begin
            mem_we <= 1'b0;
            if (ev.start) begin
                state  <= S_RX;
                phase  <= P_DEV;
                bitcnt <= '0;
                oe_q   <= 1'b0;
            end else if (ev.stop) begin
                state <= S_IDLE;
                oe_q  <= 1'b0;
            end else begin
                unique case (state)
                    S_RX: begin
                        if (ev.rise) begin
                            rx_sh  <= {rx_sh[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            unique case (phase)
                                P_DEV: begin
                                    if (code_match(rx_sh, DEV_CODE)) begin
                                        rw_q  <= rx_sh[0];
                                        oe_q  <= 1'b1;
                                        state <= S_ACK_OUT;
                                        if (rx_sh[0]) begin
                                            addr_q <= {rx_sh[HI_W:1], addr_q[BYTE_W-1:0]};
                                        end else begin
                                            addr_q[ADDR_W-1:BYTE_W] <= rx_sh[HI_W:1];
                                        end
                                    end else begin
                                        state <= S_IDLE;
                                    end
                                end
                                P_ADDR: begin
                                    addr_q[BYTE_W-1:0] <= rx_sh;
                                    oe_q  <= 1'b1;
                                    state <= S_ACK_OUT;
                                end
                                default: begin
                                    mem_we    <= ~wp_i;
                                    mem_waddr <= addr_q;
                                    mem_wdata <= rx_sh;
                                    addr_q    <= addr_q + 1'b1;
                                    oe_q      <= 1'b1;
                                    state     <= S_ACK_OUT;
                                end
                            endcase
                        end
                    end
                    S_ACK_OUT: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            if (rw_q) begin
                                tx_sh  <= rdata;
                                oe_q   <= ~rdata[BYTE_W-1];
                                addr_q <= addr_q + 1'b1;
                                state  <= S_TX;
                            end else begin
                                oe_q  <= 1'b0;
                                state <= S_RX;
                                phase <= (phase == P_DEV) ? P_ADDR : P_DATA;
                            end
                        end
                    end
                    S_TX: begin
                        if (ev.fall) begin
                            if (bitcnt == CNT_LAST) begin
                                oe_q  <= 1'b0;
                                state <= S_ACK_IN;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                oe_q   <= ~tx_sh[BYTE_W-2];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    S_ACK_IN: begin
                        if (ev.rise) begin
                            host_ack_q <= ~ev.sda;
                        end else if (ev.fall) begin
                            bitcnt <= '0;
                            if (host_ack_q) begin
                                tx_sh  <= rdata;
                                oe_q   <= ~rdata[BYTE_W-1];
                                addr_q <= addr_q + 1'b1;
                                state  <= S_TX;
                            end else begin
                                state <= S_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_BAD_CODE_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (byte_done && phase == P_DEV && !code_match(rx_sh, DEV_CODE)) |=> (!oe_q && state == S_IDLE)); // R2

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (byte_done && phase == P_DATA && addr_q == '1) |=> (addr_q == '0)); // R4

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> !oe_q); // R7

    AST_WP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !$past(wp_i)); // R8

    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_q) |-> $past(ev.fall || ev.start || ev.stop)); // R10

endmodule

// File: tb/i2cm_target_tb.sv
module i2cm_target_tb_top;

    localparam int Q     = 4;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]    ref_mem   [DEPTH];
    bit            ref_valid [DEPTH];
    logic [AW-1:0] ptr;

    always #10 clk = ~clk;

    assign sda_line = sda_h & ~sda_oe;

    i2cm_target dut_i (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_h),
        .sda_i  (sda_line),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); sda_h = 1'b0; wq(); scl_h = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wq(); scl_h = 1'b1; wq(); sda_h = 1'b1; wq(); wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_h = b[i]; wq(); scl_h = 1'b1; wq(); wq(); scl_h = 1'b0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_h = 1'b1; wq(); scl_h = 1'b1; wq();
        ack = !sda_line;
        wq(); scl_h = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_h = 1'b1; wq(); b[i] = sda_line; wq(); scl_h = 1'b0; wq();
        end
        sda_h = give_ack ? 1'b0 : 1'b1; wq(); scl_h = 1'b1; wq(); wq(); scl_h = 1'b0; wq();
        sda_h = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic [2:0] hi, input bit rd);
        return {4'b1010, hi, rd};
    endfunction

    task automatic write_seq(input logic [AW-1:0] a, input int n, input string req);
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(dev(a[10:8], 1'b0), ack); chk(ack, "R2", ack, 1);
        ptr[10:8] = a[10:8];
        send_byte(a[7:0], ack); chk(ack, "R3", ack, 1);
        ptr[7:0] = a[7:0];
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, ack); chk(ack, req, ack, 1);
            if (!wp) begin
                ref_mem[ptr] = d;
                ref_valid[ptr] = 1'b1;
            end
            ptr = ptr + 1'b1;
        end
        bus_stop();
    endtask

    task automatic read_body(input int n, input string req);
        logic [7:0] d;
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, d);
            if (ref_valid[ptr]) chk(d === ref_mem[ptr], req, d, ref_mem[ptr]);
            ptr = ptr + 1'b1;
        end
        wq();
        chk(sda_oe == 1'b0, "R7", sda_oe, 0);
        bus_stop();
    endtask

    task automatic read_rand(input logic [AW-1:0] a, input int n, input string req);
        bit ack;
        bus_start();
        send_byte(dev(a[10:8], 1'b0), ack); chk(ack, "R2", ack, 1);
        send_byte(a[7:0], ack); chk(ack, "R3", ack, 1);
        bus_start();
        send_byte(dev(a[10:8], 1'b1), ack); chk(ack, "R6", ack, 1);
        ptr = a;
        read_body(n, req);
    endtask

    task automatic read_cur(input logic [2:0] hi, input int n, input string req);
        bit ack;
        bus_start();
        send_byte(dev(hi, 1'b1), ack); chk(ack, "R2", ack, 1);
        ptr = {hi, ptr[7:0]};
        read_body(n, req);
    endtask

    logic r10_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl_h && sda_oe != r10_prev && !done) begin
            chk(1'b0, "R10", sda_oe, r10_prev);
        end
        r10_prev <= sda_oe;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] d;
        logic [AW-1:0] a;
        int n;
        void'($urandom(32'd4242));
        ptr = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        wq();
        chk(sda_oe == 1'b0, "R1 released", sda_oe, 0);

        write_seq(11'h000, 1, "R3");
        write_seq(11'h3A0, 3, "R3");
        rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0; wq();
        ptr = '0;
        read_cur(3'd0, 1, "R1 pointer");

        bus_start();
        send_byte(8'h9E, ack); chk(!ack, "R2 bad code", ack, 0);
        send_byte(8'h12, ack); chk(!ack, "R2 ignored", ack, 0);
        bus_stop();

        write_seq(11'h501, 1, "R3");
        write_seq(11'h7FE, 3, "R4");
        read_rand(11'h7FE, 3, "R4 wrap");
        read_cur(3'd5, 1, "R5");

        write_seq(11'h100, 3, "R3");
        wp = 1'b1;
        write_seq(11'h100, 2, "R8 ack");
        wp = 1'b0;
        read_cur(3'd1, 1, "R8 pointer");
        read_rand(11'h100, 2, "R8 data");

        write_seq(11'h200, 1, "R3");
        bus_start();
        send_byte(dev(3'd2, 1'b0), ack); chk(ack, "R2", ack, 1);
        send_byte(8'h00, ack); chk(ack, "R3", ack, 1);
        send_bits(8'hFF, 5);
        bus_stop();
        ptr = 11'h200;
        read_rand(11'h200, 1, "R9");

        bus_start();
        send_byte(dev(3'd2, 1'b0), ack); chk(ack, "R2", ack, 1);
        send_byte(8'h00, ack); chk(ack, "R3", ack, 1);
        ptr = 11'h200;
        send_bits(8'h00, 3);
        bus_start();
        send_byte(dev(3'd2, 1'b1), ack); chk(ack, "R11", ack, 1);
        recv_byte(1'b0, d);
        chk(d === ref_mem[11'h200], "R11", d, ref_mem[11'h200]);
        ptr = ptr + 1'b1;
        bus_stop();

        for (int it = 0; it < 12; it++) begin
            a = AW'($urandom);
            n = 1 + int'($urandom % 8);
            write_seq(a, n, "R3");
            read_rand(a, n, "R7");
        end

        done = 1'b1;
        chk(1'b1, "R10", 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule